// File: doc/BRIEF.md
# Audio Serial Bit and Frame Clock Generator

This block takes a master audio clock and produces two slower clocks for a serial audio link. The bit clock is a fixed fraction of the master clock. The frame clock (left/right select) is in turn a fraction of the bit clock. A 32-bit configuration word sets both fractions and a shared run enable. The same word also carries settings for the master clock source, which this block does not use. The master audio clock drives every flop of the block. The two outputs are registered square waves, and downstream serial logic uses them as clocks or as qualifiers.

The frame clock changes state only when the bit clock falls, so the channel boundaries always line up with bit clock edges. A new ratio takes effect at the next frame boundary, so the frame in progress is never cut short. When the enable is cleared, the outputs first finish the phase they are in and then stay low. If the frame field holds a value that has no ratio, the frame clock stays low and the bit clock keeps running.

Top module: `audclk_gen`

## Requirements
- R1: While reset is asserted, and after reset while enable (config bit 31) is 0, `bitClk` and `frameClk` are both 0.
- R2: Config bit 16 selects the bit clock ratio. Value 0 gives `bitClk` = master/2 and value 1 gives master/4. Both have 50% duty.
- R3: Config bits 19:17 select the frame ratio. Values 0, 1 and 2 give `frameClk` = `bitClk`/32, /64 and /128 with 50% duty, so one frame period holds 32, 64 or 128 bit clock rising edges.
- R4: `frameClk` changes only in the master cycle in which `bitClk` falls.
- R5: Frame field values 3 to 7 hold `frameClk` at 0, and `bitClk` keeps toggling at its selected ratio.
- R6: When enable becomes 1 from the parked state, the first rising edge of `bitClk` comes one half bit period after the master clock edge that samples the enable: 1 master cycle for ratio /2 and 2 master cycles for ratio /4.
- R7: When enable is cleared, `bitClk` completes its current high phase and `frameClk` completes its current high phase. Both then stay low until enable returns.
- R8: A change to either ratio field while running takes effect at the next falling edge of `frameClk`. The current frame finishes with the old timing.
- R9: Configuration bits other than 31 and 19:16 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master audio clock; clocks every flop in the block |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWord | input | 32 | Configuration word: bit 31 enable, bits 19:17 frame ratio, bit 16 bit ratio |
| bitClk | output | 1 | Serial bit clock |
| frameClk | output | 1 | Left/right frame clock |

## Verification
The bench targets the moments when state carries across a boundary. It changes the ratio mid-frame: a design that applied the new ratio at once would end that frame early or late. It clears the enable in two places, in the middle of a high frame phase and just after a bit clock rising edge. A design that stopped at once would clip a phase, and one that never parked would keep toggling. It also runs frame codes 3 and 7, which have no ratio, where a design that wrapped or decoded them would toggle the frame clock. It measures the delay from enable to the first bit clock edge, and it watches every frame clock change for a matching bit clock fall.

// File: rtl/audclk_pkg.sv
`timescale 1ns/1ps
package audclk_pkg;
  localparam int FRAME_FIELD_W = 3;

  // strobes and selections handed from control to the datapath
  typedef struct packed {
    logic                     run;
    logic                     bitDiv4;
    logic                     frValid;
    logic [FRAME_FIELD_W-1:0] frCode;
  } gen_ctrl_t;

  // events reported by the datapath for the current master cycle
  typedef struct packed {
    logic fallEvt;    // bit clock falls at this edge
    logic frameEnd;   // frame boundary at this edge
    logic frNextLow;  // frame clock will be low after a bit clock fall now
  } gen_stat_t;
endpackage

// File: rtl/audclk_ctrl.sv
`timescale 1ns/1ps
module audclk_ctrl
  import audclk_pkg::*;
#(
  parameter int CFG_W        = 32,
  parameter int BIT_SEL_POS  = 16,
  parameter int FR_SEL_POS   = 17,
  parameter int EN_POS       = 31,
  parameter int NUM_FR_CODES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  gen_stat_t        stat,
  output gen_ctrl_t        ctl
);
  logic                     runQ;
  logic                     bitQ;
  logic [FRAME_FIELD_W-1:0] frQ;

  logic                     enable;
  logic                     newBit;
  logic [FRAME_FIELD_W-1:0] newFr;
  logic                     parkNow;
  logic                     cfgUnused;

  assign enable    = cfgWord[EN_POS];
  assign newBit    = cfgWord[BIT_SEL_POS];
  assign newFr     = cfgWord[FR_SEL_POS +: FRAME_FIELD_W];
  assign cfgUnused = ^cfgWord;

  // stop only on a bit clock fall that leaves the frame clock low
  assign parkNow = runQ && stat.fallEvt && !enable && stat.frNextLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
      bitQ <= 1'b0;
      frQ  <= '0;
    end else if (!runQ) begin
      if (enable) begin
        runQ <= 1'b1;
        bitQ <= newBit;
        frQ  <= newFr;
      end
    end else if (parkNow) begin
      runQ <= 1'b0;
    end else if (stat.frameEnd) begin
      bitQ <= newBit;
      frQ  <= newFr;
    end
  end

  assign ctl.run     = runQ;
  assign ctl.bitDiv4 = bitQ;
  assign ctl.frCode  = frQ;
  assign ctl.frValid = (frQ < FRAME_FIELD_W'(NUM_FR_CODES));

  // R8: active ratios move only across a frame boundary
  a_r8_ratio_held_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    runQ && $past(runQ) && !$past(stat.frameEnd) |-> $stable(bitQ) && $stable(frQ));

  // R7: running stops only on a bit clock fall with enable low
  a_r7_stop_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runQ) |-> $past(stat.fallEvt) && !$past(enable));

  // R6: starting requires the enable
  a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> $past(enable));
endmodule

// File: rtl/audclk_datapath.sv
`timescale 1ns/1ps
module audclk_datapath
  import audclk_pkg::*;
#(
  parameter int HALF_BASE    = 16,
  parameter int NUM_FR_CODES = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  gen_ctrl_t ctl,
  output gen_stat_t stat,
  output logic      bitClk,
  output logic      frameClk
);
  localparam int MAX_HALF = HALF_BASE << (NUM_FR_CODES - 1);
  localparam int CNT_W    = $clog2(MAX_HALF);

  logic             pre;
  logic             bclkQ;
  logic             frclkQ;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] halfLast;
  logic             halfBitDone;
  logic             fallEvt;
  logic             wrap;

  // bit clock falls per frame half, minus one, for the active code
  always_comb begin
    halfLast = '0;
    for (int c = 0; c < NUM_FR_CODES; c++) begin
      if (ctl.frCode == FRAME_FIELD_W'(c)) halfLast = CNT_W'((HALF_BASE << c) - 1);
    end
  end

  assign halfBitDone = !ctl.bitDiv4 || pre;
  assign fallEvt     = ctl.run && halfBitDone && bclkQ;
  assign wrap        = ctl.frValid && (bitCnt == halfLast);

  assign stat.fallEvt   = fallEvt;
  assign stat.frNextLow = ctl.frValid ? !(frclkQ ^ wrap) : 1'b1;
  assign stat.frameEnd  = fallEvt && (ctl.frValid ? (wrap && frclkQ) : 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre    <= 1'b0;
      bclkQ  <= 1'b0;
      frclkQ <= 1'b0;
      bitCnt <= '0;
    end else if (!ctl.run) begin
      pre    <= 1'b0;
      bclkQ  <= 1'b0;
      frclkQ <= 1'b0;
      bitCnt <= '0;
    end else begin
      if (halfBitDone) begin
        pre   <= 1'b0;
        bclkQ <= ~bclkQ;
      end else begin
        pre <= 1'b1;
      end
      if (fallEvt) begin
        if (!ctl.frValid) begin
          frclkQ <= 1'b0;
          bitCnt <= '0;
        end else if (wrap) begin
          frclkQ <= ~frclkQ;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign bitClk   = bclkQ;
  assign frameClk = frclkQ;

  // R4: frame clock moves together with a bit clock fall
  a_r4_frame_on_bit_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frclkQ) |-> $fell(bclkQ));

  // R2: in the /4 mode a high phase lasts two master cycles
  a_r2_div4_high_two: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run && ctl.bitDiv4 && $rose(bclkQ) |=> bclkQ);

  // R5: with no ratio for the code, the frame clock stays low
  a_r5_invalid_frame_low: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run && !ctl.frValid |-> !frclkQ);

  // R1: stopped generator keeps both outputs low
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run && !$past(ctl.run) |-> !bclkQ && !frclkQ);
endmodule

// File: rtl/audclk_gen.sv
`timescale 1ns/1ps
module audclk_gen
  import audclk_pkg::*;
#(
  parameter int CFG_W        = 32,
  parameter int BIT_SEL_POS  = 16,
  parameter int FR_SEL_POS   = 17,
  parameter int EN_POS       = 31,
  parameter int HALF_BASE    = 16,
  parameter int NUM_FR_CODES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             bitClk,
  output logic             frameClk
);
  gen_ctrl_t ctl;
  gen_stat_t stat;

  audclk_ctrl #(
    .CFG_W(CFG_W), .BIT_SEL_POS(BIT_SEL_POS), .FR_SEL_POS(FR_SEL_POS),
    .EN_POS(EN_POS), .NUM_FR_CODES(NUM_FR_CODES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .stat(stat), .ctl(ctl)
  );

  audclk_datapath #(
    .HALF_BASE(HALF_BASE), .NUM_FR_CODES(NUM_FR_CODES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat),
    .bitClk(bitClk), .frameClk(frameClk)
  );
endmodule

// File: tb/test_audclk_gen.sv
`timescale 1ns/1ps
module test_audclk_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        bitClk;
  logic        frameClk;

  audclk_gen i_audclk_gen (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .bitClk(bitClk), .frameClk(frameClk)
  );

  always #2ns clk = ~clk;

  int nChk = 0;
  int nErr = 0;
  int alignBad = 0;
  logic bNow = 0, fNow = 0, pb = 0, pf = 0;

  localparam int NV = 7;
  localparam int vBit [NV] = '{0, 1, 0, 1, 0, 1, 0};
  localparam int vFr  [NV] = '{0, 0, 1, 1, 2, 2, 1};
  localparam int vBitPer [NV] = '{2, 4, 2, 4, 2, 4, 2};
  localparam int vFrPer  [NV] = '{64, 128, 128, 256, 256, 512, 128};
  localparam logic [31:0] vNoise [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h7FF0_FFFF};

  function automatic logic [31:0] mk(input bit en, input int b, input int f, input logic [31:0] noise);
    logic [31:0] r;
    r = noise;
    r[31] = en;
    r[16] = b[0];
    r[19:17] = f[2:0];
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one master cycle, sampled at the falling edge
  task automatic step();
    @(negedge clk);
    pb = bNow; pf = fNow;
    bNow = bitClk; fNow = frameClk;
    if (fNow != pf && !(pb && !bNow)) alignBad++;
  endtask

  task automatic waitFrRise();
    for (int i = 0; i < 2000; i++) begin
      step();
      if (!pf && fNow) break;
    end
  endtask

  task automatic park();
    cfgWord = '0;
    for (int i = 0; i < 700; i++) step();
  endtask

  initial begin
    #800us;
    nChk++; nErr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    int t, rises, highT, n;
    // R1: reset state
    for (int i = 0; i < 3; i++) step();
    chk("R1 reset bitClk", bNow, 0);
    chk("R1 reset frameClk", fNow, 0);
    rstN = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin step(); if (bNow || fNow) n++; end
    chk("R1 disabled outputs low", n, 0);

    // vector table: R2, R3, R9
    for (int v = 0; v < NV; v++) begin
      park();
      cfgWord = mk(1'b1, vBit[v], vFr[v], vNoise[v]);
      waitFrRise();
      t = 0; rises = 0; highT = 0;
      for (int i = 0; i < 2000; i++) begin
        step(); t++;
        if (!pb && bNow) rises++;
        if (pf && !fNow) highT = t;
        if (!pf && fNow) break;
      end
      chk(v == 6 ? "R9 frame period" : "R3 frame period", t, vFrPer[v]);
      chk(v == 6 ? "R9 frame high" : "R3 frame high", highT, vFrPer[v] / 2);
      chk("R3 bit edges per frame", rises, vFrPer[v] / vBitPer[v]);
      t = 0;
      for (int i = 0; i < 100; i++) begin step(); if (!pb && bNow) break; end
      for (int i = 0; i < 100; i++) begin step(); t++; if (!pb && bNow) break; end
      chk(v == 6 ? "R9 bit period" : "R2 bit period", t, vBitPer[v]);
    end

    // R6: start latency for both bit ratios
    park();
    cfgWord = mk(1'b1, 0, 0, 32'h0);
    n = 0;
    for (int i = 0; i < 10; i++) begin step(); n++; if (bNow) break; end
    chk("R6 first rise /2", n, 2);
    park();
    cfgWord = mk(1'b1, 1, 0, 32'h0);
    n = 0;
    for (int i = 0; i < 10; i++) begin step(); n++; if (bNow) break; end
    chk("R6 first rise /4", n, 3);

    // R5: codes without a ratio
    park();
    cfgWord = mk(1'b1, 0, 3, 32'h0);
    rises = 0; n = 0;
    for (int i = 0; i < 1200; i++) begin step(); if (!pb && bNow) rises++; if (fNow) n++; end
    chk("R5 code3 frame high samples", n, 0);
    chk("R5 code3 bit rises", rises, 600);
    park();
    cfgWord = mk(1'b1, 1, 7, 32'h0);
    rises = 0; n = 0;
    for (int i = 0; i < 1200; i++) begin step(); if (!pb && bNow) rises++; if (fNow) n++; end
    chk("R5 code7 frame high samples", n, 0);
    chk("R5 code7 bit rises", rises, 300);

    // R7: disable during a high frame phase
    park();
    cfgWord = mk(1'b1, 0, 0, 32'h0);
    waitFrRise();
    for (int i = 0; i < 4; i++) step();
    cfgWord = '0;
    n = 0;
    for (int i = 0; i < 200; i++) begin step(); n++; if (!fNow) break; end
    chk("R7 frame high completes", n, 28);
    n = 0;
    for (int i = 0; i < 600; i++) begin step(); if (bNow || fNow) n++; end
    chk("R7 parked low", n, 0);

    // R7: disable just after a bit clock rise, /4
    cfgWord = mk(1'b1, 1, 0, 32'h0);
    waitFrRise();
    for (int i = 0; i < 2000; i++) begin step(); if (pf && !fNow) break; end
    for (int i = 0; i < 20; i++) begin step(); if (!pb && bNow) break; end
    cfgWord = '0;
    step();
    chk("R7 bit high completes", bNow, 1);
    step();
    chk("R7 bit low after phase", bNow, 0);
    n = 0;
    for (int i = 0; i < 400; i++) begin step(); if (bNow || fNow) n++; end
    chk("R7 parked after bit phase", n, 0);

    // R8: ratio change mid-frame
    cfgWord = mk(1'b1, 0, 0, 32'h0);
    waitFrRise();
    for (int i = 0; i < 6; i++) step();
    cfgWord = mk(1'b1, 1, 1, 32'h0);
    n = 0;
    for (int i = 0; i < 300; i++) begin step(); n++; if (!fNow) break; end
    chk("R8 old frame finishes", n, 26);
    n = 0;
    for (int i = 0; i < 300; i++) begin step(); n++; if (fNow) break; end
    chk("R8 new low phase", n, 128);
    n = 0;
    for (int i = 0; i < 300; i++) begin step(); n++; if (!fNow) break; end
    chk("R8 new high phase", n, 128);

    chk("R4 frame changes on bit fall", alignBad, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule